// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

A clocked static RAM model with a 72-bit word made of eight 9-bit byte lanes. The address, write data and every control input except the output enable and the two static mode selects are captured on the rising clock edge. An access starts when one of two active-low address strobes is asserted. The processor strobe is honoured only while the primary enable is low. The controller strobe always acts, and it deselects the device when the enables do not all agree.

Once an access has started, an active-low advance input steps a 2-bit burst count. The low two address bits then follow linear (wrapping) or interleaved order, chosen by a static pin, while the upper bits stay fixed. A write can be global, covering every lane, or limited to the lanes whose active-low lane strobes are asserted. Read data leaves the array in the cycle the address is captured (flow-through) or one cycle later (pipelined), according to a second static pin. An asynchronous active-low output enable gates the data port.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and after it is released with no strobe, the device is inactive: `dout_en` is 0 and `dout` is all zeros.
- R2: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at a strobe edge; a processor strobe with `ce1_n`=0 but another enable inactive deselects it.
- R3: A processor strobe (`adsp_n`=0) sampled with `ce1_n`=1 is ignored: a burst in progress keeps its address and continues to be accessed.
- R4: A controller strobe (`adsc_n`=0) sampled with any enable inactive deselects the device; no read data is presented until a new selecting strobe.
- R5: With `burst_il`=0, each sampled `adv_n`=0 moves the low two address bits to (start + count) mod 4, where count steps 0,1,2,3 and wraps; the upper address bits do not change.
- R6: With `burst_il`=1, the low two address bits are start XOR count.
- R7: With no strobe and no advance, the current burst address is held and the same location is accessed again.
- R8: While the device is deselected, `adv_n` has no effect and no access takes place.
- R9: A selected cycle is a write when `gw_n`=0 or `we_n`=0. With `gw_n`=0 all eight lanes are written; otherwise lane i (bits 9i+8..9i, lane a = i 0) is written when `bw_n[i]`=0. A write cycle presents no read data.
- R10: With `pipe_mode`=0, read data captured at edge k is presented on `dout` from just after edge k until edge k+1.
- R11: With `pipe_mode`=1, read data captured at edge k is presented from just after edge k+1 until edge k+2.
- R12: `oe_n`=1 forces `dout_en` to 0 and `dout` to zero at once, without waiting for a clock edge; `oe_n`=0 restores the output at once.
- R13: Either strobe asserted during a burst aborts it and restarts the access at the newly captured address with the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address; the low two bits are the burst start offset |
| din | input | 72 | Write data, eight 9-bit lanes |
| gw_n | input | 1 | Global write of all lanes, active low |
| we_n | input | 1 | Lane-selected write, active low |
| bw_n | input | 8 | Per-lane write strobes, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3_n | input | 1 | Depth-expansion enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| pipe_mode | input | 1 | Static read path: 0 flow-through, 1 pipelined |
| dout | output | 72 | Read data, zero when not driven |
| dout_en | output | 1 | High while `dout` carries read data |

## Verification
Two functions can land in the same cycle: a strobe that restarts or deselects the device, and the advance or hold of the burst already running. In the pipelined path, a restart can also coincide with the last read of the old burst still leaving the output register. The bench provokes both by asserting a strobe together with `adv_n`=0 in the middle of a burst, in both read modes, and by asserting the processor strobe with `ce1_n` high while advancing. A behavioural model judges each case every clock. It gives the strobe priority, and it keeps the previous read in flight for one more cycle when pipelined.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adsp_n,
  input  logic                     adsc_n,
  input  logic                     adv_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W*NBYTES-1:0] din,
  input  logic                     gw_n,
  input  logic                     we_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     oe_n,
  input  logic                     burst_il,
  input  logic                     pipe_mode,
  output logic [BYTE_W*NBYTES-1:0] dout,
  output logic                     dout_en
);
  localparam int DATA_W = BYTE_W * NBYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              act;
  logic [1:0]        cnt;
  logic [ADDR_W-1:0] base;
  logic              rv, pv;
  logic [DATA_W-1:0] rq, pq;

  wire sel_in = !ce1_n && ce2 && !ce3_n;
  wire p_go   = !adsp_n && !ce1_n;
  wire strobe = p_go || !adsc_n;
  wire is_wr  = !gw_n || !we_n;
  wire cyc_on = strobe ? sel_in : act;

  logic [1:0]        cnt_n, off;
  logic [ADDR_W-1:0] base_n, ea;
  logic [NBYTES-1:0] wmask;

  always_comb begin
    base_n = strobe ? addr : base;
    if (strobe)                cnt_n = 2'd0;
    else if (act && !adv_n)    cnt_n = cnt + 2'd1;
    else                       cnt_n = cnt;
    off    = burst_il ? (base_n[1:0] ^ cnt_n) : (base_n[1:0] + cnt_n);
    ea     = {base_n[ADDR_W-1:2], off};
    wmask  = !gw_n ? '1 : (!we_n ? ~bw_n : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      cnt  <= 2'd0;
      base <= '0;
      rv   <= 1'b0;
      pv   <= 1'b0;
    end else begin
      act  <= cyc_on;
      cnt  <= cnt_n;
      base <= base_n;
      rv   <= cyc_on && !is_wr;
      pv   <= rv;
    end
  end

  always_ff @(posedge clk) begin
    if (cyc_on && !is_wr) rq <= mem[ea];
    pq <= rq;
    if (cyc_on && is_wr)
      for (int b = 0; b < NBYTES; b++)
        if (wmask[b]) mem[ea][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
  end

  assign dout_en = !oe_n && (pipe_mode ? pv : rv);
  assign dout    = dout_en ? (pipe_mode ? pq : rq) : '0;

  a_r3_adsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce1_n && adsc_n && adv_n) |=> ($stable(cnt) && $stable(base) && $stable(act)));
  a_r4_adsc_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && ce1_n) |=> (!act && !rv));
  a_r5_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (act && adsc_n && adsp_n && !adv_n && cnt == 2'd3) |=> (cnt == 2'd0));
  a_r8_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && adsc_n && adsp_n) |=> (!act && !rv));
  a_r11_pipe_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && !$past(rv)) |-> !dout_en);
endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, gw_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [71:0] din = '0;
  logic [7:0] bw_n = '1;
  logic ce1_n = 0, ce2 = 1, ce3_n = 0, oe_n = 0, burst_il = 0, pipe_mode = 0;
  logic [71:0] dout;
  logic dout_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) i_burst_sram (.*);

  logic [71:0] mmem [0:(1<<AW)-1];
  bit m_act, m_rv, m_pv;
  logic [71:0] m_rq, m_pq;
  int m_start, m_cnt, m_a, m_off;
  bit m_strb, m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_rv = 0; m_pv = 0; m_cnt = 0; m_start = 0;
    end else begin
      m_pv = m_rv; m_pq = m_rq;
      m_strb = (!adsp_n && !ce1_n) || !adsc_n;
      m_sel  = !ce1_n && ce2 && !ce3_n;
      if (m_strb) begin m_act = m_sel; m_start = int'(addr); m_cnt = 0; end
      else if (m_act && !adv_n) m_cnt = (m_cnt + 1) % 4;
      m_off = burst_il ? ((m_start % 4) ^ m_cnt) : ((m_start % 4 + m_cnt) % 4);
      m_a = (m_start / 4) * 4 + m_off;
      m_rv = 0;
      if (m_act) begin
        if (!gw_n || !we_n) begin
          for (int b = 0; b < 8; b++)
            if (!gw_n || !bw_n[b]) mmem[m_a][b*9 +: 9] = din[b*9 +: 9];
        end else begin
          m_rv = 1; m_rq = mmem[m_a];
        end
      end
    end
  end

  task automatic compare(string req);
    bit e_en;
    logic [71:0] e_d;
    e_en = !oe_n && (pipe_mode ? m_pv : m_rv);
    e_d  = e_en ? (pipe_mode ? m_pq : m_rq) : '0;
    checks++;
    if (dout_en !== e_en || dout !== e_d) begin
      failures++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h", req, dout_en, dout, e_en, e_d);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk); #2; compare(req);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; we_n = 1; bw_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  function automatic logic [71:0] pat(int i);
    return 72'(i) * 72'h0F1E2D3C4B5A6978 + 72'h1F3;
  endfunction

  task automatic read_burst(int a, int n, string req);
    idle(); adsp_n = 0; addr = AW'(a); tick(req);
    idle();
    for (int k = 0; k < n; k++) begin adv_n = 0; tick(req); end
    idle(); tick(req); tick(req);
  endtask

  initial begin
    #1; compare("R1");
    #20; compare("R1");
    rst_n = 1;
    tick("R1"); tick("R1");
    for (int i = 0; i < 16; i++) begin
      idle(); adsc_n = 0; addr = AW'(i); din = pat(i); gw_n = 0; tick("R9");
    end
    idle(); tick("R9");
    burst_il = 0; read_burst(5, 5, "R5");
    read_burst(10, 3, "R10");
    burst_il = 1; read_burst(6, 4, "R6");
    read_burst(13, 5, "R6");
    burst_il = 0;
    idle(); adsp_n = 0; addr = 8'd2; tick("R7");
    idle(); tick("R7"); tick("R7"); tick("R7");
    adv_n = 0; tick("R5");
    idle(); adsp_n = 0; ce1_n = 1; adv_n = 0; addr = 8'd12; tick("R3");
    idle(); tick("R3");
    adsp_n = 0; ce1_n = 1; addr = 8'd9; tick("R3"); idle(); tick("R3");
    adsc_n = 0; ce1_n = 1; addr = 8'd1; tick("R4");
    idle(); tick("R4");
    for (int k = 0; k < 3; k++) begin adv_n = 0; tick("R8"); end
    idle(); tick("R8");
    adsp_n = 0; ce2 = 0; addr = 8'd3; tick("R2"); idle(); tick("R2");
    adsp_n = 0; ce3_n = 1; addr = 8'd3; tick("R2"); idle(); tick("R2");
    adsc_n = 0; addr = 8'd3; tick("R2"); idle(); tick("R2");
    idle(); adsc_n = 0; addr = 8'd8; we_n = 0; bw_n = 8'b1010_1010; din = '1; tick("R9");
    idle(); adv_n = 0; we_n = 0; bw_n = 8'b0101_0101; din = '0; tick("R9");
    idle(); adv_n = 0; we_n = 0; bw_n = 8'hFF; din = '1; tick("R9");
    idle(); tick("R9");
    read_burst(8, 3, "R9");
    read_burst(4, 2, "R13");
    idle(); adsc_n = 0; addr = 8'd1; tick("R13");
    idle(); adv_n = 0; tick("R13");
    adsp_n = 0; addr = 8'd14; tick("R13");
    idle(); adv_n = 0; tick("R13"); adv_n = 0; tick("R13"); idle(); tick("R13");
    pipe_mode = 1; #1; compare("R11");
    read_burst(0, 5, "R11");
    idle(); adsp_n = 0; addr = 8'd7; tick("R11");
    idle(); adv_n = 0; tick("R11");
    adsc_n = 0; addr = 8'd11; tick("R13");
    idle(); adv_n = 0; tick("R11");
    adsc_n = 0; ce1_n = 1; tick("R4"); idle(); tick("R11"); tick("R11");
    idle(); adsp_n = 0; addr = 8'd2; tick("R11");
    idle(); tick("R11"); tick("R11");
    oe_n = 1; #1; compare("R12");
    oe_n = 0; #1; compare("R12");
    oe_n = 1; tick("R12"); oe_n = 0; #1; compare("R12");
    pipe_mode = 0; #1; compare("R10");
    tick("R10");
    oe_n = 1; #1; compare("R12");
    oe_n = 0; #1; compare("R12");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule